// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Status Register

This block is the arithmetic and logic datapath of a small accumulator-style processor. Each cycle it takes a working-register operand `w_i`, a second operand `f_i` (a file register or an immediate, chosen outside the block) and an operation code. It returns a combinational result and a double-width product. It also reports which status bits the operation is allowed to change.

The status bits are carry, digit carry, zero, overflow and negative. They live in a register inside the block. Carry and digit carry feed back into the operations that consume them: add with carry, subtract with borrow, rotate through carry and decimal adjust. The status register is written on the clock edge where `exec_i` is high, and only in the bits the current operation enables. Operand fetch, result write-back and sequencing belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Reset clears the status register; `status_o` holds C in bit 0, DC in bit 1, Z in bit 2, OV in bit 3 and N in bit 4.
- R2: Code 0 gives w+f and code 1 gives w+f+C. C is the carry out of bit 7, DC is the carry out of bit 3, and OV is set on signed two's-complement overflow.
- R3: Code 2 gives f−w and code 3 gives w−f. Code 4 gives f−w−(1−C) and code 5 gives w−f−(1−C). C is set when the full subtraction does not borrow, DC is set when the low nibbles do not borrow, and OV is set on signed overflow.
- R4: Code 10 gives the two's complement negate 0−f, code 11 gives f+1 and code 12 gives f−1. All three set C, DC and OV with the add and subtract rules above.
- R5: The logic codes are AND (6), OR (7), XOR (8) and complement of f (9), plus 20 (all ones) and 21 (all zeros). They write only Z and N and leave C, DC and OV unchanged.
- R6: Code 13 rotates {f,C} left and code 14 rotates it right, both as a 9-bit rotation in which the bit shifted out becomes C. Code 15 rotates f left and code 16 rotates it right, both as an 8-bit rotation that writes only Z and N.
- R7: Code 17 exchanges the two nibbles of f and writes no status bit.
- R8: `prod_o` always carries the unsigned 16-bit product w×f. Code 18 returns the product's low byte on `res_o` and writes no status bit.
- R9: Code 19 adjusts w to packed BCD in two stages. The first stage adds 6 when w[3:0]>9 or DC=1. The second stage adds 0x60 when the high nibble of that first-stage result is >9 or C=1. C becomes 1 if it was already set or if either stage carries out. Code 19 writes C, Z and N.
- R10: `flag_we_o` is the per-operation status write mask, laid out like `status_o`. Whenever Z or N is written, Z records a zero result and N records result bit 7. Unused codes (22 to 31) give a zero result and an empty mask.
- R11: The status register changes only on an edge where `exec_i` is high, and only in the bits set in `flag_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Commit status update on this edge |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File or literal operand |
| res_o | output | 8 | Operation result |
| prod_o | output | 16 | Unsigned product w×f |
| flag_we_o | output | 5 | Status bits written by this operation |
| status_o | output | 5 | Registered status {N,OV,Z,DC,C} |

## Verification
`res_o`, `prod_o` and `flag_we_o` are combinational and respond in the same cycle as the operands and code. The bench drives each operation on the falling edge and samples these outputs one time unit later, before the next rising edge. `status_o` changes only at the rising edge that follows an `exec_i` cycle, so the bench advances its own status model at that edge and compares shortly after it. The carry and digit carry that the next operation consumes therefore always come from the model's committed state.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_ADD    = 5'd0,
      OP_ADDC   = 5'd1,
      OP_SUBFW  = 5'd2,
      OP_SUBWF  = 5'd3,
      OP_SUBFWB = 5'd4,
      OP_SUBWFB = 5'd5,
      OP_AND    = 5'd6,
      OP_OR     = 5'd7,
      OP_XOR    = 5'd8,
      OP_NOT    = 5'd9,
      OP_NEG    = 5'd10,
      OP_INC    = 5'd11,
      OP_DEC    = 5'd12,
      OP_RLC    = 5'd13,
      OP_RRC    = 5'd14,
      OP_RL     = 5'd15,
      OP_RR     = 5'd16,
      OP_SWAP   = 5'd17,
      OP_MUL    = 5'd18,
      OP_DADJ   = 5'd19,
      OP_ONES   = 5'd20,
      OP_ZERO   = 5'd21
   } alu_op_e;

   localparam int FLG_C  = 0;
   localparam int FLG_DC = 1;
   localparam int FLG_Z  = 2;
   localparam int FLG_OV = 3;
   localparam int FLG_N  = 4;
   localparam int FLG_W  = 5;

   localparam logic [FLG_W-1:0] MASK_ALL = 5'b11111;
   localparam logic [FLG_W-1:0] MASK_ZN  = 5'b10100;
   localparam logic [FLG_W-1:0] MASK_CZN = 5'b10101;
   localparam logic [FLG_W-1:0] MASK_NON = 5'b00000;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             hcout_o,
   output logic             ovf_o
);
   logic [WIDTH:0] full;
   logic [4:0]     low;

   assign full    = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
   assign low     = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'b0, cin_i};
   assign sum_o   = full[WIDTH-1:0];
   assign cout_o  = full[WIDTH];
   assign hcout_o = low[4];
   assign ovf_o   = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (full[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/alu8_bitmove.sv
module alu8_bitmove #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] f_i,
   input  logic             cin_i,
   input  logic [2:0]       sel_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   localparam int HALF = WIDTH / 2;

   always_comb begin
      res_o  = f_i;
      cout_o = cin_i;
      case (sel_i)
         3'd0: begin
            res_o  = {f_i[WIDTH-2:0], cin_i};
            cout_o = f_i[WIDTH-1];
         end
         3'd1: begin
            res_o  = {cin_i, f_i[WIDTH-1:1]};
            cout_o = f_i[0];
         end
         3'd2:    res_o = {f_i[WIDTH-2:0], f_i[WIDTH-1]};
         3'd3:    res_o = {f_i[0], f_i[WIDTH-1:1]};
         default: res_o = {f_i[HALF-1:0], f_i[WIDTH-1:HALF]};
      endcase
   end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] w_i,
   input  logic             dc_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   localparam int NIB = WIDTH / 4;

   logic [NIB:0][WIDTH-1:0] acc;
   logic [NIB:0]            cy;

   assign acc[0] = w_i;
   assign cy[0]  = 1'b0;

   for (genvar k = 0; k < NIB; k++) begin : g_stage
      localparam logic [WIDTH:0] SIX = {{(WIDTH-3){1'b0}}, 4'd6} << (4*k);
      logic           frc;
      logic           fix;
      logic [3:0]     nib;
      logic [WIDTH:0] sum;

      if (k == 0) begin : g_lo
         assign frc = dc_i;
      end else if (k == NIB-1) begin : g_hi
         assign frc = c_i;
      end else begin : g_mid
         assign frc = 1'b0;
      end

      assign nib        = acc[k][4*k +: 4];
      assign fix        = (nib > 4'd9) | frc;
      assign sum        = {1'b0, acc[k]} + (fix ? SIX : '0);
      assign acc[k+1]   = sum[WIDTH-1:0];
      assign cy[k+1]    = cy[k] | sum[WIDTH];
   end

   assign res_o  = acc[NIB];
   assign cout_o = cy[NIB];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int MUL_EN = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_i,
   input  logic [4:0]         op_i,
   input  logic [WIDTH-1:0]   w_i,
   input  logic [WIDTH-1:0]   f_i,
   output logic [WIDTH-1:0]   res_o,
   output logic [2*WIDTH-1:0] prod_o,
   output logic [FLG_W-1:0]   flag_we_o,
   output logic [FLG_W-1:0]   status_o
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH % 4 != 0 || WIDTH < 8) begin : g_bad_width
      $error("alu8_core: WIDTH must be a multiple of 4 and at least 8");
   end
   if (MUL_EN != 0 && MUL_EN != 1) begin : g_bad_mul
      $error("alu8_core: MUL_EN must be 0 or 1");
   end

   alu_op_e          op;
   logic [FLG_W-1:0] status_q;
   logic [FLG_W-1:0] nxt;
   logic             c_q, dc_q;
   logic [WIDTH-1:0] add_a, add_b, add_sum;
   logic             add_ci, add_co, add_hc, add_ov;
   logic [2:0]       mv_sel;
   logic [WIDTH-1:0] mv_res;
   logic             mv_co;
   logic [WIDTH-1:0] da_res;
   logic             da_co;
   logic [PW-1:0]    prod;
   logic             c_new, dc_new, ov_new;

   assign op   = alu_op_e'(op_i);
   assign c_q  = status_q[FLG_C];
   assign dc_q = status_q[FLG_DC];

   // operand steering for the shared adder
   always_comb begin
      add_a  = w_i;
      add_b  = f_i;
      add_ci = 1'b0;
      case (op)
         OP_ADDC:   add_ci = c_q;
         OP_SUBFW:  begin add_a = f_i;  add_b = ~w_i; add_ci = 1'b1; end
         OP_SUBWF:  begin add_a = w_i;  add_b = ~f_i; add_ci = 1'b1; end
         OP_SUBFWB: begin add_a = f_i;  add_b = ~w_i; add_ci = c_q;  end
         OP_SUBWFB: begin add_a = w_i;  add_b = ~f_i; add_ci = c_q;  end
         OP_NEG:    begin add_a = '0;   add_b = ~f_i; add_ci = 1'b1; end
         OP_INC:    begin add_a = f_i;  add_b = '0;   add_ci = 1'b1; end
         OP_DEC:    begin add_a = f_i;  add_b = '1;   add_ci = 1'b0; end
         default:   ;
      endcase
   end

   alu8_addsub #(.WIDTH(WIDTH)) i_addsub (
      .a_i(add_a), .b_i(add_b), .cin_i(add_ci),
      .sum_o(add_sum), .cout_o(add_co), .hcout_o(add_hc), .ovf_o(add_ov)
   );

   always_comb begin
      case (op)
         OP_RLC:  mv_sel = 3'd0;
         OP_RRC:  mv_sel = 3'd1;
         OP_RL:   mv_sel = 3'd2;
         OP_RR:   mv_sel = 3'd3;
         default: mv_sel = 3'd4;
      endcase
   end

   alu8_bitmove #(.WIDTH(WIDTH)) i_bitmove (
      .f_i(f_i), .cin_i(c_q), .sel_i(mv_sel), .res_o(mv_res), .cout_o(mv_co)
   );

   alu8_decadj #(.WIDTH(WIDTH)) i_decadj (
      .w_i(w_i), .dc_i(dc_q), .c_i(c_q), .res_o(da_res), .cout_o(da_co)
   );

   if (MUL_EN == 1) begin : g_mul
      assign prod = {{WIDTH{1'b0}}, w_i} * {{WIDTH{1'b0}}, f_i};
   end else begin : g_nomul
      assign prod = '0;
   end
   assign prod_o = prod;

   // result selection and status write mask
   always_comb begin
      res_o     = '0;
      flag_we_o = MASK_NON;
      c_new     = add_co;
      dc_new    = add_hc;
      ov_new    = add_ov;
      case (op)
         OP_ADD, OP_ADDC, OP_SUBFW, OP_SUBWF, OP_SUBFWB, OP_SUBWFB,
         OP_NEG, OP_INC, OP_DEC: begin
            res_o     = add_sum;
            flag_we_o = MASK_ALL;
         end
         OP_AND:  begin res_o = w_i & f_i; flag_we_o = MASK_ZN; end
         OP_OR:   begin res_o = w_i | f_i; flag_we_o = MASK_ZN; end
         OP_XOR:  begin res_o = w_i ^ f_i; flag_we_o = MASK_ZN; end
         OP_NOT:  begin res_o = ~f_i;      flag_we_o = MASK_ZN; end
         OP_ONES: begin res_o = '1;        flag_we_o = MASK_ZN; end
         OP_ZERO: begin res_o = '0;        flag_we_o = MASK_ZN; end
         OP_RLC, OP_RRC: begin
            res_o     = mv_res;
            c_new     = mv_co;
            flag_we_o = MASK_CZN;
         end
         OP_RL, OP_RR: begin res_o = mv_res; flag_we_o = MASK_ZN; end
         OP_SWAP: res_o = mv_res;
         OP_MUL:  res_o = prod[WIDTH-1:0];
         OP_DADJ: begin
            res_o     = da_res;
            c_new     = c_q | da_co;
            flag_we_o = MASK_CZN;
         end
         default: ;
      endcase
   end

   always_comb begin
      nxt         = '0;
      nxt[FLG_C]  = c_new;
      nxt[FLG_DC] = dc_new;
      nxt[FLG_Z]  = (res_o == '0);
      nxt[FLG_OV] = ov_new;
      nxt[FLG_N]  = res_o[WIDTH-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (exec_i) begin
         for (int i = 0; i < FLG_W; i++) begin
            if (flag_we_o[i]) status_q[i] <= nxt[i];
         end
      end
   end

   assign status_o = status_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(status_o)); // R11
   AST_Z_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && flag_we_o[FLG_Z] |=> status_o[FLG_Z] == ($past(res_o) == '0)); // R10
   AST_N_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && flag_we_o[FLG_N] |=> status_o[FLG_N] == $past(res_o[WIDTH-1])); // R10
   AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOT)
      |=> $stable(status_o[FLG_C]) && $stable(status_o[FLG_OV])); // R5
   AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && (op == OP_SWAP || op == OP_MUL) |=> $stable(status_o)); // R7

   if (MUL_EN == 1) begin : g_mul_chk
      AST_MUL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_MUL) |-> res_o == prod_o[WIDTH-1:0]); // R8
   end
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [4:0]  op_i = '0;
   logic [7:0]  w_i = '0;
   logic [7:0]  f_i = '0;
   logic [7:0]  res_o;
   logic [15:0] prod_o;
   logic [4:0]  flag_we_o;
   logic [4:0]  status_o;

   int total = 0;
   int bad = 0;
   logic [4:0] ms = '0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core i_alu8_core (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
      .w_i(w_i), .f_i(f_i), .res_o(res_o), .prod_o(prod_o),
      .flag_we_o(flag_we_o), .status_o(status_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sg(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   task automatic m_add(input int a, input int b, input int ci,
                        output int r, output int c, output int dc, output int ov);
      int s;
      r  = (a + b + ci) & 255;
      c  = ((a + b + ci) > 255) ? 1 : 0;
      dc = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
      s  = sg(a) + sg(b) + ci;
      ov = (s > 127 || s < -128) ? 1 : 0;
   endtask

   task automatic m_sub(input int x, input int y, input int bo,
                        output int r, output int c, output int dc, output int ov);
      int s;
      r  = (x - y - bo) & 255;
      c  = ((x - y - bo) >= 0) ? 1 : 0;
      dc = (((x & 15) - (y & 15) - bo) >= 0) ? 1 : 0;
      s  = sg(x) - sg(y) - bo;
      ov = (s > 127 || s < -128) ? 1 : 0;
   endtask

   function automatic string tag_of(input int op);
      if (op <= 1) return "R2";
      if (op <= 5) return "R3";
      if (op <= 9 || op == 20 || op == 21) return "R5";
      if (op <= 12) return "R4";
      if (op <= 16) return "R6";
      if (op == 17) return "R7";
      if (op == 18) return "R8";
      if (op == 19) return "R9";
      return "R10";
   endfunction

   // behavioural reference: result, write mask and next status
   task automatic ref_eval(input int op, input int w, input int f,
                           output int r, output int we, output logic [4:0] nx);
      int c, dc, ov, cin, dcin, t, hi;
      cin = ms[0]; dcin = ms[1];
      c = cin; dc = dcin; ov = ms[3];
      r = 0; we = 0;
      case (op)
         0:  begin m_add(w, f, 0, r, c, dc, ov);    we = 31; end
         1:  begin m_add(w, f, cin, r, c, dc, ov);  we = 31; end
         2:  begin m_sub(f, w, 0, r, c, dc, ov);    we = 31; end
         3:  begin m_sub(w, f, 0, r, c, dc, ov);    we = 31; end
         4:  begin m_sub(f, w, 1-cin, r, c, dc, ov); we = 31; end
         5:  begin m_sub(w, f, 1-cin, r, c, dc, ov); we = 31; end
         6:  begin r = w & f; we = 20; end
         7:  begin r = w | f; we = 20; end
         8:  begin r = w ^ f; we = 20; end
         9:  begin r = 255 - f; we = 20; end
         10: begin m_sub(0, f, 0, r, c, dc, ov);    we = 31; end
         11: begin m_add(f, 1, 0, r, c, dc, ov);    we = 31; end
         12: begin m_sub(f, 1, 0, r, c, dc, ov);    we = 31; end
         13: begin r = ((f * 2) & 255) + cin; c = f / 128; we = 21; end
         14: begin r = (f / 2) + cin * 128; c = f % 2; we = 21; end
         15: begin r = ((f * 2) & 255) + f / 128; we = 20; end
         16: begin r = (f / 2) + (f % 2) * 128; we = 20; end
         17: begin r = (f % 16) * 16 + f / 16; we = 0; end
         18: begin r = (w * f) % 256; we = 0; end
         19: begin
            t = w;
            if ((t % 16) > 9 || dcin == 1) t = t + 6;
            if (t > 255) begin c = 1; t = t - 256; end
            hi = t / 16;
            if (hi > 9 || cin == 1) t = t + 96;
            if (t > 255) begin c = 1; t = t - 256; end
            r = t; we = 21;
         end
         20: begin r = 255; we = 20; end
         21: begin r = 0; we = 20; end
         default: begin r = 0; we = 0; end
      endcase
      nx = ms;
      if (we & 1)  nx[0] = c[0];
      if (we & 2)  nx[1] = dc[0];
      if (we & 4)  nx[2] = (r == 0);
      if (we & 8)  nx[3] = ov[0];
      if (we & 16) nx[4] = (r >= 128);
   endtask

   task automatic step(input int op, input int w, input int f, input bit ex);
      int r, we;
      logic [4:0] nx;
      string tg;
      tg = tag_of(op);
      @(negedge clk);
      op_i = op[4:0]; w_i = w[7:0]; f_i = f[7:0]; exec_i = ex;
      #1;
      ref_eval(op, w, f, r, we, nx);
      check(tg, "res_o", int'(res_o), r);
      check("R8", "prod_o", int'(prod_o), w * f);
      check("R10", "flag_we_o", int'(flag_we_o), we);
      @(posedge clk);
      #1;
      if (ex) ms = nx;
      check(ex ? tg : "R11", "status_o", int'(status_o), int'(ms));
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset holds status at zero even with exec requested
      op_i = 5'd0; w_i = 8'hFF; f_i = 8'h01; exec_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exec_i = 1'b0;
      rst_n = 1'b1;
      #1;
      check("R1", "status_o after reset", int'(status_o), 0);

      // R2: carry, digit carry, zero, overflow
      step(0, 8'hFF, 8'h01, 1);
      check("R2", "ADD FF+01 status", int'(status_o), 5'b00111);
      step(0, 8'h7F, 8'h01, 1);
      check("R2", "ADD 7F+01 status", int'(status_o), 5'b11010);
      step(0, 8'h80, 8'h80, 1);
      step(1, 8'h10, 8'h20, 1);
      step(1, 8'h0F, 8'h00, 1);
      // R3: subtraction orderings and borrow use
      step(2, 8'h05, 8'h03, 1);
      step(4, 8'h05, 8'h03, 1);
      step(3, 8'h05, 8'h03, 1);
      step(5, 8'h80, 8'h01, 1);
      step(5, 8'h00, 8'h00, 1);
      step(4, 8'h01, 8'h01, 1);
      // R4
      step(10, 8'h00, 8'h00, 1);
      step(10, 8'h00, 8'h80, 1);
      step(11, 8'h00, 8'hFF, 1);
      step(12, 8'h00, 8'h00, 1);
      step(12, 8'h00, 8'h80, 1);
      // R5: logic keeps carry set by a prior rotate
      step(13, 8'h00, 8'h80, 1);
      step(6, 8'hF0, 8'h0F, 1);
      check("R5", "C kept after AND", int'(status_o[0]), 1);
      step(7, 8'h00, 8'h80, 1);
      step(8, 8'hAA, 8'hAA, 1);
      step(9, 8'h00, 8'h00, 1);
      step(20, 8'h00, 8'h00, 1);
      step(21, 8'h00, 8'h00, 1);
      // R6
      step(13, 8'h00, 8'h55, 1);
      step(14, 8'h00, 8'h01, 1);
      step(14, 8'h00, 8'h00, 1);
      step(15, 8'h00, 8'h81, 1);
      step(16, 8'h00, 8'h01, 1);
      // R7, R8
      step(17, 8'h00, 8'h3C, 1);
      step(18, 8'hFF, 8'hFF, 1);
      step(18, 8'h12, 8'h10, 1);
      // R9: decimal adjust corners
      step(21, 8'h00, 8'h00, 1);
      step(14, 8'h00, 8'h00, 1);   // C = 0
      step(3, 8'h00, 8'h01, 1);    // borrow: C=0, DC=0
      step(19, 8'h9A, 8'h00, 1);
      check("R9", "DADJ 9A result", int'(res_o), 8'h00);
      check("R9", "DADJ 9A carry", int'(status_o[0]), 1);
      step(0, 8'h09, 8'h08, 1);    // 0x11 with DC set
      step(19, 8'h11, 8'h00, 1);
      check("R9", "DADJ with DC result", int'(res_o), 8'h17);
      step(19, 8'h45, 8'h00, 1);
      step(19, 8'h3F, 8'h00, 1);
      // R10: unused codes; R11: exec low leaves status
      step(22, 8'h12, 8'h34, 1);
      step(31, 8'h00, 8'h00, 1);
      step(0, 8'hFF, 8'h01, 0);
      step(21, 8'h00, 8'h00, 0);

      for (int n = 0; n < 600; n++) begin
         step($urandom_range(0, 31), $urandom_range(0, 255),
              $urandom_range(0, 255), ($urandom_range(0, 3) != 0));
      end

      finish_run();
   end
endmodule